// File: doc/BRIEF.md
# Paired-Word Load/Store Issue Sequencer

This block takes one doubleword load or store, decodes its addressing form and works out two counts. The first is the number of issue cycles the form costs. The second is the number of memory beats the access needs. It forms the offset from an immediate or from a shifted register value, applies the sign, and selects pre- or post-indexed addressing. It then places the beats one at a time on a single-ported 32-bit request bus that uses a valid/ready handshake.

While an instruction is in flight the block raises a busy signal, and it accepts nothing new until the final beat has been accepted. Alongside the beats it reports which source registers the form needs early and the updated base value, so that a pipeline can schedule operand reads and base writeback. Register storage, the data path, caches and faults are handled elsewhere.

Top module: `dw_pair_seq`

## Requirements
- R1: After reset, `busy` and `mem_req_valid` are 0.
- R2: A form takes one issue cycle (`issue_cycles` = 1) when the offset is an immediate of either sign. It also takes one issue cycle when the offset is a positive register with shift kind LSL (code 0) and an amount of 0 or 2.
- R3: Every other register-offset form takes two issue cycles (`issue_cycles` = 2). This covers a negative register offset, LSR (code 1), ASR (code 2), ROR (code 3), and LSL with an amount other than 0 or 2.
- R4: `early_off` is 1 exactly for register offsets. `early_base` is 1 exactly for the one-issue forms.
- R5: The number of accepted beats equals the issue count when the access address has bits [2:0] = 0, and equals the issue count plus one otherwise.
- R6: Beat k carries address {addr[31:2],2'b00} + 4k. `mem_req_pair` is 1 only when the access has a single beat.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the address and valid are held unchanged into the next cycle.
- R8: `busy` rises in the cycle after `in_valid` is taken and falls in the cycle after the last beat is accepted. `in_valid` is ignored while `busy` is 1.
- R9: The register offset is `off_val` shifted by `shift_amt` according to the shift kind: LSL = 0, LSR = 1, ASR = 2, ROR = 3. An immediate offset is `off_val` unshifted. `off_neg` subtracts the offset instead of adding it.
- R10: With `post_index` = 0 the access address is base plus the signed offset. With `post_index` = 1 it is the base itself.
- R11: `wb_en` = `writeback` OR `post_index`, and `wb_value` = base plus the signed offset.
- R12: `mem_req_we` follows `is_store` of the instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New instruction present |
| off_is_reg | input | 1 | 1 = register offset, 0 = immediate |
| off_neg | input | 1 | 1 = subtract offset |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift amount |
| post_index | input | 1 | 1 = post-indexed addressing |
| writeback | input | 1 | Base writeback requested |
| is_store | input | 1 | 1 = store, 0 = load |
| base_val | input | 32 | Base register value |
| off_val | input | 32 | Offset register value or immediate |
| busy | output | 1 | Instruction in flight; issue stall |
| issue_cycles | output | 2 | Issue cycles of the form in flight |
| early_base | output | 1 | Base register read early |
| early_off | output | 1 | Offset register read early |
| wb_en | output | 1 | Base is written back |
| wb_value | output | 32 | Updated base value |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Beat request accepted |
| mem_req_addr | output | 32 | Word address of the beat |
| mem_req_we | output | 1 | Beat is a write |
| mem_req_pair | output | 1 | Beat moves the whole aligned doubleword |

## Verification
The bench builds the block with its default widths: a 32-bit address and a 2-bit beat counter. This covers the full three-beat case and every shift kind across all 32 bits, so shift amounts such as 4 and ROR wraparound can be checked against hand-computed offsets. Each addressing form is run with a doubleword-aligned target, a word-misaligned target and a byte-misaligned target. The bench throttles `mem_req_ready` so that held requests and the beat count under back-pressure are both exercised.

// File: rtl/dwseq_pkg.sv
package dwseq_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;
endpackage

// File: rtl/dwseq_decode.sv
module dwseq_decode
  import dwseq_pkg::*;
#(
  parameter int SHAMT_W = 5,
  parameter int CNT_W   = 2
) (
  input  logic               off_is_reg,
  input  logic               off_neg,
  input  shift_e             kind,
  input  logic [SHAMT_W-1:0] amt,
  input  logic [2:0]         addr_lo,
  output logic [CNT_W-1:0]   issue_cnt,
  output logic [CNT_W-1:0]   beat_cnt,
  output logic               early_base,
  output logic               early_off
);
  logic plain_shift;
  logic single;

  always_comb begin
    plain_shift = (kind == SH_LSL) &&
                  ((amt == SHAMT_W'(0)) || (amt == SHAMT_W'(2)));
    single      = !off_is_reg || (!off_neg && plain_shift);
    issue_cnt   = single ? CNT_W'(1) : CNT_W'(2);
    beat_cnt    = issue_cnt + ((addr_lo != 3'b000) ? CNT_W'(1) : CNT_W'(0));
    early_base  = single;
    early_off   = off_is_reg;
  end
endmodule

// File: rtl/dwseq_agen.sv
module dwseq_agen
  import dwseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  off,
  input  logic               off_is_reg,
  input  logic               off_neg,
  input  shift_e             kind,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               post,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic [ADDR_W-1:0]  new_base
);
  logic [ADDR_W-1:0]  shifted;
  logic [ADDR_W-1:0]  mag;
  logic [SHAMT_W:0]   rot_back;

  always_comb begin
    rot_back = (SHAMT_W+1)'(ADDR_W) - {1'b0, amt};
    unique case (kind)
      SH_LSL:  shifted = off << amt;
      SH_LSR:  shifted = off >> amt;
      SH_ASR:  shifted = ADDR_W'($signed(off) >>> amt);
      default: shifted = (off >> amt) | (off << rot_back);
    endcase
    mag      = off_is_reg ? shifted : off;
    new_base = off_neg ? (base - mag) : (base + mag);
    acc_addr = post ? base : new_base;
  end
endmodule

// File: rtl/dwseq_beat_ctrl.sv
module dwseq_beat_ctrl #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] beat_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic             fire, last;

  always_comb begin
    fire    = busy_q && ready_i;
    last    = (beat_q == total_q - CNT_W'(1));
    busy_d  = busy_q;
    beat_d  = beat_q;
    total_d = total_q;
    if (start_i) begin
      busy_d  = 1'b1;
      beat_d  = '0;
      total_d = total_i;
    end else if (fire) begin
      if (last) busy_d = 1'b0;
      else      beat_d = beat_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      total_q <= '0;
    end else begin
      busy_q  <= busy_d;
      beat_q  <= beat_d;
      total_q <= total_d;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;

  assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (beat_q < total_q));
  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready_i) |=> (busy_q && $stable(beat_q)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> !busy_q);
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(fire && last)) |=> $stable(total_q));
endmodule

// File: rtl/dw_pair_seq.sv
module dw_pair_seq
  import dwseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHAMT_W = $clog2(ADDR_W),
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               off_is_reg,
  input  logic               off_neg,
  input  logic [1:0]         shift_kind,
  input  logic [SHAMT_W-1:0] shift_amt,
  input  logic               post_index,
  input  logic               writeback,
  input  logic               is_store,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  off_val,
  output logic               busy,
  output logic [CNT_W-1:0]   issue_cycles,
  output logic               early_base,
  output logic               early_off,
  output logic               wb_en,
  output logic [ADDR_W-1:0]  wb_value,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic               mem_req_we,
  output logic               mem_req_pair
);
  localparam int WORD_SH = 2;

  shift_e             kind;
  logic [ADDR_W-1:0]  acc_addr, new_base;
  logic [CNT_W-1:0]   dec_issue, dec_beats, beat;
  logic               dec_eb, dec_eo, start;

  logic [ADDR_W-1:0]  addr_q, wbv_q;
  logic [CNT_W-1:0]   issue_q, beats_q;
  logic               eb_q, eo_q, wben_q, we_q;

  assign kind  = shift_e'(shift_kind);
  assign start = in_valid && !busy;

  dwseq_agen #(.ADDR_W(ADDR_W), .SHAMT_W(SHAMT_W)) agen_i (
    .base(base_val), .off(off_val), .off_is_reg(off_is_reg),
    .off_neg(off_neg), .kind(kind), .amt(shift_amt), .post(post_index),
    .acc_addr(acc_addr), .new_base(new_base)
  );

  dwseq_decode #(.SHAMT_W(SHAMT_W), .CNT_W(CNT_W)) dec_i (
    .off_is_reg(off_is_reg), .off_neg(off_neg), .kind(kind),
    .amt(shift_amt), .addr_lo(acc_addr[2:0]),
    .issue_cnt(dec_issue), .beat_cnt(dec_beats),
    .early_base(dec_eb), .early_off(dec_eo)
  );

  dwseq_beat_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .total_i(dec_beats),
    .ready_i(mem_req_ready), .busy_o(busy), .beat_o(beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wbv_q   <= '0;
      issue_q <= '0;
      beats_q <= '0;
      eb_q    <= 1'b0;
      eo_q    <= 1'b0;
      wben_q  <= 1'b0;
      we_q    <= 1'b0;
    end else if (start) begin
      addr_q  <= acc_addr;
      wbv_q   <= new_base;
      issue_q <= dec_issue;
      beats_q <= dec_beats;
      eb_q    <= dec_eb;
      eo_q    <= dec_eo;
      wben_q  <= writeback || post_index;
      we_q    <= is_store;
    end
  end

  always_comb begin
    mem_req_valid = busy;
    mem_req_addr  = {addr_q[ADDR_W-1:WORD_SH], {WORD_SH{1'b0}}}
                    + (ADDR_W'(beat) << WORD_SH);
    mem_req_pair  = (beats_q == CNT_W'(1));
    mem_req_we    = we_q;
    issue_cycles  = issue_q;
    early_base    = eb_q;
    early_off     = eo_q;
    wb_en         = wben_q;
    wb_value      = wbv_q;
  end

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_pair_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_pair) |-> (mem_req_addr[2:0] == 3'b000));
  assert_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (early_base == (issue_cycles == CNT_W'(1))));
  assert_extra_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((beats_q == issue_q) || (beats_q == issue_q + CNT_W'(1))));
endmodule

// File: tb/dw_pair_seq_tb_top.sv
`timescale 1ns/1ps
module dw_pair_seq_tb_top;
  typedef struct packed {
    logic        is_reg;
    logic        neg;
    logic [1:0]  kind;
    logic [4:0]  amt;
    logic        post;
    logic        wb;
    logic        store;
    logic [31:0] offv;
    logic [31:0] eoff;
    logic [1:0]  eiss;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,5'd0,1'b0,1'b1,1'b0,32'h10,32'h10,2'd1},
    '{1'b0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b1,32'h20,32'hFFFF_FFE0,2'd1},
    '{1'b1,1'b0,2'd0,5'd0,1'b0,1'b1,1'b0,32'h8,32'h8,2'd1},
    '{1'b1,1'b0,2'd0,5'd2,1'b0,1'b0,1'b1,32'h3,32'hC,2'd1},
    '{1'b1,1'b1,2'd0,5'd0,1'b0,1'b1,1'b0,32'h8,32'hFFFF_FFF8,2'd2},
    '{1'b1,1'b0,2'd0,5'd1,1'b0,1'b0,1'b0,32'h3,32'h6,2'd2},
    '{1'b1,1'b0,2'd1,5'd4,1'b0,1'b0,1'b1,32'h100,32'h10,2'd2},
    '{1'b1,1'b0,2'd2,5'd4,1'b0,1'b1,1'b0,32'hFFFF_FF00,32'hFFFF_FFF0,2'd2},
    '{1'b1,1'b0,2'd3,5'd4,1'b0,1'b0,1'b0,32'h10,32'h1,2'd2},
    '{1'b1,1'b1,2'd0,5'd2,1'b0,1'b1,1'b1,32'h2,32'hFFFF_FFF8,2'd2},
    '{1'b0,1'b0,2'd0,5'd0,1'b1,1'b0,1'b0,32'h18,32'h18,2'd1},
    '{1'b1,1'b1,2'd1,5'd1,1'b1,1'b0,1'b1,32'h10,32'hFFFF_FFF8,2'd2},
    '{1'b1,1'b0,2'd1,5'd2,1'b0,1'b0,1'b0,32'h40,32'h10,2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, off_is_reg, off_neg, post_index, writeback, is_store;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic [31:0] base_val, off_val;
  logic        busy, early_base, early_off, wb_en;
  logic [1:0]  issue_cycles;
  logic [31:0] wb_value, mem_req_addr;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_req_pair;

  int n_run  = 0;
  int n_fail = 0;
  int phase  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dw_pair_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .off_is_reg(off_is_reg),
    .off_neg(off_neg), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .post_index(post_index), .writeback(writeback), .is_store(is_store),
    .base_val(base_val), .off_val(off_val), .busy(busy),
    .issue_cycles(issue_cycles), .early_base(early_base),
    .early_off(early_off), .wb_en(wb_en), .wb_value(wb_value),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
    .mem_req_pair(mem_req_pair)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic [31:0] base);
    off_is_reg = v.is_reg;  off_neg   = v.neg;   shift_kind = v.kind;
    shift_amt  = v.amt;     post_index = v.post; writeback = v.wb;
    is_store   = v.store;   off_val   = v.offv;  base_val   = base;
  endtask

  // One instruction to a chosen access address; stall_start holds ready low
  // for the first cycles and pulses in_valid with another form meanwhile.
  task automatic run_vec(input vec_t v, input logic [31:0] target,
                         input int stall_start);
    logic [31:0] base, waddr, prev_addr;
    int exp_beats, beats, guard;
    bit prev_stall;
    base      = v.post ? target : target - v.eoff;
    waddr     = {target[31:2], 2'b00};
    exp_beats = int'(v.eiss) + ((target[2:0] != 3'b000) ? 1 : 0);
    @(negedge clk);
    drive(v, base);
    in_valid = 1'b1;
    mem_req_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy === 1'b1, "R8", "busy after take", 32'(busy), 32'd1);
    chk(issue_cycles === v.eiss, v.eiss == 2'd1 ? "R2" : "R3", "issue",
        32'(issue_cycles), 32'(v.eiss));
    chk(early_off === v.is_reg, "R4", "early_off", 32'(early_off), 32'(v.is_reg));
    chk(early_base === (v.eiss == 2'd1), "R4", "early_base",
        32'(early_base), 32'(v.eiss == 2'd1));
    chk(wb_en === (v.wb | v.post), "R11", "wb_en", 32'(wb_en), 32'(v.wb | v.post));
    chk(wb_value === base + v.eoff, "R9", "wb_value", wb_value, base + v.eoff);
    chk(mem_req_we === v.store, "R12", "we", 32'(mem_req_we), 32'(v.store));
    beats = 0; guard = 0; prev_stall = 1'b0; prev_addr = '0;
    while (busy === 1'b1 && guard < 60) begin
      if (stall_start > 0) begin
        mem_req_ready = 1'b0;
        stall_start--;
        drive(VECS[6], 32'h0000_3000);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
        mem_req_ready = ((phase % 3) != 1);
        phase++;
      end
      if (prev_stall)
        chk(mem_req_addr === prev_addr && mem_req_valid === 1'b1, "R7",
            "held request", mem_req_addr, prev_addr);
      if (mem_req_valid && mem_req_ready) begin
        chk(mem_req_addr === waddr + 32'(beats * 4), "R6", "beat addr",
            mem_req_addr, waddr + 32'(beats * 4));
        chk(mem_req_pair === (exp_beats == 1), "R6", "pair flag",
            32'(mem_req_pair), 32'(exp_beats == 1));
        beats++;
      end
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      @(negedge clk);
      guard++;
    end
    in_valid = 1'b0;
    mem_req_ready = 1'b0;
    chk(beats == exp_beats, "R5", "beat count", 32'(beats), 32'(exp_beats));
    chk(busy === 1'b0 && mem_req_valid === 1'b0, "R8", "released",
        32'(busy), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mem_req_ready = 1'b0;
    drive(VECS[0], 32'h0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    chk(mem_req_valid === 1'b0, "R1", "valid in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);

    // Sweep: every form against aligned, word-misaligned and byte-misaligned
    // targets (R2 R3 R5 R6 R10).
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], 32'h0000_2000, 0);
      run_vec(VECS[i], 32'h0000_2004, 0);
      run_vec(VECS[i], 32'h0000_2003, 0);
    end

    // R10: post-indexed access goes to the unmodified base.
    run_vec(VECS[10], 32'h0000_4008, 0);
    // R8: new instruction offered while busy and stalled is ignored;
    // the beat count and issue count stay those of the first form.
    run_vec(VECS[0], 32'h0000_5004, 3);
    @(negedge clk);
    chk(busy === 1'b0, "R8", "no late start", 32'(busy), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule